// File: doc/BRIEF.md
# CAN Global Control Sequencer

This block holds the 8-bit global control byte of a CAN controller and turns it into control actions for an abstracted protocol engine and a bank of message objects. Software writes the byte over a plain byte-wide write strobe and reads it back combinationally. The engine reports frame events as single-cycle pulses. These are start of frame, last bit of end of frame, frame done and overload frame start. It also shows which mailbox owns the frame now on the bus.

A four-state sequencer brings the controller up and takes it down. The states are `ST_OFF`, `ST_WAKE`, `ST_RUN` and `ST_DRAIN`, with these transitions:

- OFF→WAKE when the run bit is set.
- WAKE→RUN after `WAKE_CYC` cycles.
- WAKE→OFF if the run bit is dropped during wake-up.
- RUN→OFF on an idle disable.
- RUN→DRAIN on a disable while a frame is in flight.
- DRAIN→OFF once that frame is done.
- DRAIN→RUN if the run bit is set again.

A software reset in any state forces OFF.

The block also has a sticky abort. It clears the enable of every mailbox except the one whose frame is still on the bus. There is a self-clearing overload request, a listen-only output, and a timer capture strobe whose capture point is chosen by a sync bit in time-triggered mode.

Top module: `can_gctl`

## Requirements
- R1: After hardware reset, bus_rdata reads 0x00, ctl_enable=0, clk_gate_en=0, tx_force_rec=1, mob_en_clr=0, ovl_req=0, listen_only=0.
- R2: Bit layout of the byte: 7 abort, 6 overload request, 5 time-triggered mode, 4 sync-on-end-of-frame, 3 listen, 2 test, 1 run, 0 soft reset. A write stores bits 7..1. The test bit (2) reads back and changes no output.
- R3: A write with bit 0 set resets the byte to 0x00 on that edge and forces the sequencer to OFF, whatever the other written bits are. Bit 0 always reads 0.
- R4: When run is written to 1 at edge k, clk_gate_en rises after edge k+1. ctl_enable rises and tx_force_rec falls after edge k+1+WAKE_CYC (k+3 by default).
- R5: When run is written to 0 at edge k with no frame in flight, ctl_enable and clk_gate_en fall and tx_force_rec rises after edge k+1.
- R6: When run is cleared while a frame is in flight, ctl_enable stays 1 until the edge that sees ev_frame_done, and falls after that edge.
- R7: While abort is set in RUN or DRAIN, mob_en_clr has every bit set except the frame_mob bit of a frame in flight. In OFF or WAKE it is all zero.
- R8: The abort bit is not self-clearing. It stays set after the frame finishes until software writes it to 0.
- R9: The overload request bit (ovl_req) is set by a write and cleared on the edge where ev_ovl_start is high.
- R10: If a write sets the overload request in the same cycle as ev_ovl_start, the bit ends at 0 only if it was already 1 before that cycle; otherwise it ends at 1.
- R11: tmr_capture equals ev_eof_last when time-triggered and sync bits are both 1. It equals ev_sof when time-triggered is 1 and sync is 0. It is 0 when time-triggered is 0 or ctl_enable is 0.
- R12: listen_only follows bit 3 of the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_wr | input | 1 | Write strobe for the control byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current control byte |
| ev_sof | input | 1 | Start-of-frame pulse from the engine |
| ev_eof_last | input | 1 | Last bit of end-of-frame pulse |
| ev_frame_done | input | 1 | Frame completed pulse |
| ev_ovl_start | input | 1 | Overload frame transmission started |
| frame_mob | input | NUM_MOB | One-hot mailbox owning the frame in flight |
| ctl_enable | output | 1 | Controller state machine active |
| clk_gate_en | output | 1 | Controller clock gate enable |
| tx_force_rec | output | 1 | Force recessive level on transmit |
| mob_en_clr | output | NUM_MOB | Per-mailbox enable clear |
| ovl_req | output | 1 | Overload frame request to the engine |
| listen_only | output | 1 | Listen-only mode |
| tmr_capture | output | 1 | Timer capture strobe |

## Verification
Two pairs of events can land in the same cycle. The first is a software write to the overload bit and the engine's overload-start pulse. The bench drives both in one cycle, once with the bit previously clear and once with it previously set, and then reads the byte back against R10. The second is an abort write while a frame is in flight. There the bench checks that only the busy mailbox is spared, and that it is cleared once the frame-done pulse lands.

// File: rtl/can_gctl_pkg.sv
package can_gctl_pkg;

    localparam int GCTL_W = 8;

    typedef struct packed {
        logic abort;
        logic ovl;
        logic ttm;
        logic sync_eof;
        logic listen;
        logic test;
        logic run;
        logic srst;
    } gctl_reg_t;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAKE,
        ST_RUN,
        ST_DRAIN
    } seq_state_e;

endpackage

// File: rtl/can_gctl_reg.sv
module can_gctl_reg
    import can_gctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [GCTL_W-1:0] bus_wdata,
    input  logic              ev_ovl_start,
    output gctl_reg_t         reg_q,
    output logic              sw_rst
);

    gctl_reg_t wr_val;

    assign sw_rst = bus_wr & bus_wdata[0];
    assign wr_val = gctl_reg_t'(bus_wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (sw_rst) begin
            reg_q <= '0;
        end else if (bus_wr) begin
            reg_q          <= wr_val;
            reg_q.srst     <= 1'b0;
            reg_q.ovl      <= wr_val.ovl & ~(ev_ovl_start & reg_q.ovl);
        end else if (ev_ovl_start) begin
            reg_q.ovl      <= 1'b0;
        end
    end

    // R3: soft reset empties the byte on the next edge
    assert_soft_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata[0]) |=> (reg_q == '0));

    // R9: a pending overload request is dropped when its frame starts
    assert_ovl_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.ovl && ev_ovl_start && !bus_wr) |=> !reg_q.ovl);

    // R8: abort is never dropped without a write
    assert_abort_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.abort && !bus_wr) |=> reg_q.abort);

endmodule

// File: rtl/can_gctl_seq.sv
module can_gctl_seq
    import can_gctl_pkg::*;
#(
    parameter int WAKE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic run_bit,
    input  logic in_frame,
    input  logic ev_frame_done,
    output logic ctl_enable,
    output logic clk_gate_en,
    output logic tx_force_rec
);

    localparam int CNT_W = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            ST_OFF: begin
                if (run_bit) state_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (!run_bit)               state_d = ST_OFF;
                else if (cnt_q == CNT_LAST) state_d = ST_RUN;
                else                        cnt_d   = cnt_q + 1'b1;
            end
            ST_RUN: begin
                if (!run_bit)
                    state_d = (in_frame && !ev_frame_done) ? ST_DRAIN : ST_OFF;
            end
            ST_DRAIN: begin
                if (run_bit)                           state_d = ST_RUN;
                else if (ev_frame_done || !in_frame)   state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else if (sw_rst) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        ctl_enable   = 1'b0;
        clk_gate_en  = 1'b0;
        tx_force_rec = 1'b1;
        unique case (state_q)
            ST_OFF: begin
            end
            ST_WAKE: begin
                clk_gate_en = 1'b1;
            end
            ST_RUN, ST_DRAIN: begin
                clk_gate_en  = 1'b1;
                ctl_enable   = 1'b1;
                tx_force_rec = 1'b0;
            end
            default: begin
            end
        endcase
    end

    // R4: the clock is already running when the controller turns active
    assert_gate_before_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_enable) |-> $past(clk_gate_en));

    // R5: idle disable leaves RUN on the next edge
    assert_idle_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !run_bit && !in_frame && !sw_rst) |=> !ctl_enable);

    // R6: drain holds until the frame is done
    assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && in_frame && !ev_frame_done && !run_bit && !sw_rst)
        |=> (state_q == ST_DRAIN));

endmodule

// File: rtl/can_gctl_evt.sv
module can_gctl_evt #(
    parameter int NUM_MOB = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_rst,
    input  logic               ctl_enable,
    input  logic               ev_sof,
    input  logic               ev_eof_last,
    input  logic               ev_frame_done,
    input  logic               ttm,
    input  logic               sync_eof,
    input  logic               abort,
    input  logic [NUM_MOB-1:0] frame_mob,
    output logic               in_frame,
    output logic               tmr_capture,
    output logic [NUM_MOB-1:0] mob_en_clr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     in_frame <= 1'b0;
        else if (sw_rst)                in_frame <= 1'b0;
        else if (ev_sof && ctl_enable)  in_frame <= 1'b1;
        else if (ev_frame_done)         in_frame <= 1'b0;
    end

    assign tmr_capture = ctl_enable & ttm & (sync_eof ? ev_eof_last : ev_sof);

    for (genvar i = 0; i < NUM_MOB; i++) begin : g_mob
        assign mob_en_clr[i] = abort & ctl_enable & ~(in_frame & frame_mob[i]);
    end

    // R7: the mailbox on the bus is never cleared mid-frame
    assert_spare_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame |-> ((mob_en_clr & frame_mob) == '0));

endmodule

// File: rtl/can_gctl.sv
module can_gctl
    import can_gctl_pkg::*;
#(
    parameter int NUM_MOB  = 15,
    parameter int WAKE_CYC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic               ev_sof,
    input  logic               ev_eof_last,
    input  logic               ev_frame_done,
    input  logic               ev_ovl_start,
    input  logic [NUM_MOB-1:0] frame_mob,
    output logic               ctl_enable,
    output logic               clk_gate_en,
    output logic               tx_force_rec,
    output logic [NUM_MOB-1:0] mob_en_clr,
    output logic               ovl_req,
    output logic               listen_only,
    output logic               tmr_capture
);

    gctl_reg_t reg_q;
    logic      sw_rst;
    logic      in_frame;

    can_gctl_reg u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .ev_ovl_start (ev_ovl_start),
        .reg_q        (reg_q),
        .sw_rst       (sw_rst)
    );

    can_gctl_seq #(.WAKE_CYC(WAKE_CYC)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_rst        (sw_rst),
        .run_bit       (reg_q.run),
        .in_frame      (in_frame),
        .ev_frame_done (ev_frame_done),
        .ctl_enable    (ctl_enable),
        .clk_gate_en   (clk_gate_en),
        .tx_force_rec  (tx_force_rec)
    );

    can_gctl_evt #(.NUM_MOB(NUM_MOB)) u_evt (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_rst        (sw_rst),
        .ctl_enable    (ctl_enable),
        .ev_sof        (ev_sof),
        .ev_eof_last   (ev_eof_last),
        .ev_frame_done (ev_frame_done),
        .ttm           (reg_q.ttm),
        .sync_eof      (reg_q.sync_eof),
        .abort         (reg_q.abort),
        .frame_mob     (frame_mob),
        .in_frame      (in_frame),
        .tmr_capture   (tmr_capture),
        .mob_en_clr    (mob_en_clr)
    );

    assign bus_rdata   = reg_q;
    assign ovl_req     = reg_q.ovl;
    assign listen_only = reg_q.listen;

    // R11: no capture strobe outside time-triggered mode
    assert_capture_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[5] |-> !tmr_capture);

    // R7: a stopped controller never clears mailbox enables
    assert_frozen_mobs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_gate_en |-> (mob_en_clr == '0));

endmodule

// File: tb/tb_can_gctl.sv
`timescale 1ns/1ps
module tb_can_gctl;

    localparam int NM = 15;
    localparam logic [NM-1:0] ALL1 = {NM{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          ev_sof = 1'b0, ev_eof_last = 1'b0, ev_frame_done = 1'b0, ev_ovl_start = 1'b0;
    logic [NM-1:0] frame_mob = '0;
    logic          ctl_enable, clk_gate_en, tx_force_rec, ovl_req, listen_only, tmr_capture;
    logic [NM-1:0] mob_en_clr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    can_gctl #(.NUM_MOB(NM), .WAKE_CYC(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ev_sof(ev_sof), .ev_eof_last(ev_eof_last),
        .ev_frame_done(ev_frame_done), .ev_ovl_start(ev_ovl_start),
        .frame_mob(frame_mob), .ctl_enable(ctl_enable), .clk_gate_en(clk_gate_en),
        .tx_force_rec(tx_force_rec), .mob_en_clr(mob_en_clr), .ovl_req(ovl_req),
        .listen_only(listen_only), .tmr_capture(tmr_capture)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        bus_wr = 1'b1;
        bus_wdata = d;
        step();
        bus_wr = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic go_run();
        wr(8'h02);
        repeat (3) step();
    endtask

    task automatic t_reset();
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 enable", ctl_enable, 0);
        chk("R1 gate", clk_gate_en, 0);
        chk("R1 recessive", tx_force_rec, 1);
        chk("R1 mob", mob_en_clr, 0);
        chk("R1 ovl", ovl_req, 0);
        chk("R1 listen", listen_only, 0);
    endtask

    task automatic t_test_listen();
        wr(8'h04);
        chk("R2 test readback", bus_rdata, 8'h04);
        chk("R2 test no gate", clk_gate_en, 0);
        chk("R2 test no enable", ctl_enable, 0);
        chk("R2 test no listen", listen_only, 0);
        chk("R2 test recessive", tx_force_rec, 1);
        wr(8'h08);
        chk("R12 listen on", listen_only, 1);
        chk("R2 listen readback", bus_rdata, 8'h08);
        wr(8'h00);
        chk("R12 listen off", listen_only, 0);
    endtask

    task automatic t_enable_latency();
        wr(8'h02);
        chk("R4 gate k", clk_gate_en, 0);
        step();
        chk("R4 gate k+1", clk_gate_en, 1);
        chk("R4 enable k+1", ctl_enable, 0);
        step();
        chk("R4 enable k+2", ctl_enable, 0);
        step();
        chk("R4 enable k+3", ctl_enable, 1);
        chk("R4 dominant allowed", tx_force_rec, 0);
    endtask

    task automatic t_disable_idle();
        wr(8'h00);
        chk("R5 still on at k", ctl_enable, 1);
        step();
        chk("R5 enable off", ctl_enable, 0);
        chk("R5 gate off", clk_gate_en, 0);
        chk("R5 recessive", tx_force_rec, 1);
    endtask

    task automatic t_disable_drain();
        go_run();
        ev_sof = 1'b1; step(); ev_sof = 1'b0;
        wr(8'h00);
        step();
        chk("R6 drain enable", ctl_enable, 1);
        step();
        chk("R6 drain hold", ctl_enable, 1);
        ev_frame_done = 1'b1; step(); ev_frame_done = 1'b0;
        chk("R6 off after done", ctl_enable, 0);
        chk("R6 recessive after done", tx_force_rec, 1);
    endtask

    task automatic t_abort();
        go_run();
        frame_mob = NM'(1) << 3;
        ev_sof = 1'b1; step(); ev_sof = 1'b0;
        wr(8'h82);
        chk("R7 busy mailbox spared", mob_en_clr, ALL1 & ~(NM'(1) << 3));
        ev_frame_done = 1'b1; step(); ev_frame_done = 1'b0;
        frame_mob = '0;
        chk("R7 all cleared after frame", mob_en_clr, ALL1);
        chk("R8 abort sticky", bus_rdata[7], 1);
        wr(8'h02);
        chk("R8 abort cleared by write", mob_en_clr, 0);
        wr(8'h01);
        wr(8'h80);
        chk("R7 frozen when off", mob_en_clr, 0);
        wr(8'h00);
    endtask

    task automatic t_overload();
        wr(8'h40);
        chk("R9 ovl set", ovl_req, 1);
        ev_ovl_start = 1'b1; step(); ev_ovl_start = 1'b0;
        chk("R9 ovl cleared", ovl_req, 0);
        ev_ovl_start = 1'b1; wr(8'h40); ev_ovl_start = 1'b0;
        chk("R10 set wins when was clear", bus_rdata[6], 1);
        ev_ovl_start = 1'b1; wr(8'h40); ev_ovl_start = 1'b0;
        chk("R10 clear wins when was set", bus_rdata[6], 0);
        wr(8'h00);
    endtask

    task automatic t_capture();
        go_run();
        wr(8'h22);
        ev_sof = 1'b1; #1;
        chk("R11 sof capture", tmr_capture, 1);
        ev_sof = 1'b0; ev_eof_last = 1'b1; #1;
        chk("R11 eof ignored sync0", tmr_capture, 0);
        ev_eof_last = 1'b0;
        step();
        wr(8'h32);
        ev_eof_last = 1'b1; #1;
        chk("R11 eof capture", tmr_capture, 1);
        ev_eof_last = 1'b0; ev_sof = 1'b1; #1;
        chk("R11 sof ignored sync1", tmr_capture, 0);
        ev_sof = 1'b0;
        step();
        wr(8'h02);
        ev_sof = 1'b1; ev_eof_last = 1'b1; #1;
        chk("R11 off when not ttm", tmr_capture, 0);
        ev_sof = 1'b0; ev_eof_last = 1'b0;
        step();
    endtask

    task automatic t_gres();
        wr(8'hFE);
        chk("R2 byte stored", bus_rdata, 8'hFE);
        wr(8'hFF);
        chk("R3 byte cleared", bus_rdata, 8'h00);
        chk("R3 sequencer off", ctl_enable, 0);
        chk("R3 gate off", clk_gate_en, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_test_listen();
        t_enable_latency();
        t_disable_idle();
        t_disable_drain();
        t_abort();
        t_overload();
        t_capture();
        t_gres();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule